// File: doc/BRIEF.md
# Privileged Instruction Trap Checker

This block rules on four privileged instructions: wait-for-interrupt and three address-translation fences (the supervisor fence, the guest-virtual fence and the guest-physical fence). For each request it decides whether the instruction may proceed or must trap. It bases that decision on the current privilege level, whether the hart runs virtualized, whether the supervisor and hypervisor extensions are enabled, and four trap-control bits. Two of these bits come from the machine status register: timeout-wait and trap-virtual-memory. The other two come from the hypervisor status register: their virtual-timeout-wait and virtual-trap-virtual-memory counterparts.

A decode stage presents one request per cycle with a valid strobe. One cycle later the block answers with exactly one of three pulses. A halt request means a wait-for-interrupt that is allowed to stall the hart. A flush request means a fence that is allowed to invalidate translations. An exception carries its cause code: illegal instruction or virtual instruction. Whatever consumes those pulses (the translation cache, the wake-up logic, the pipeline) lies outside the block.

Top module: `priv_trap_gate`

## Requirements
- R1: A wait-for-interrupt (op code 0) raises illegal instruction when timeout-wait is set and the hart is in S mode (virtualized or not), or in U mode with the supervisor extension disabled.
- R2: A wait-for-interrupt in non-virtualized U mode with the supervisor extension enabled raises illegal instruction, whatever timeout-wait holds.
- R3: A wait-for-interrupt that R1 and R2 do not trap raises a virtual-instruction fault when virtualized in U mode, or virtualized in S mode with virtual-timeout-wait set.
- R4: A wait-for-interrupt that R1 to R3 do not trap, including every one from M mode, produces a halt request.
- R5: A supervisor fence (op code 1) raises illegal instruction in U mode, or in S mode with trap-virtual-memory set.
- R6: A supervisor fence that R5 does not trap raises a virtual-instruction fault when the hypervisor extension is enabled, the hart is virtualized and virtual-trap-virtual-memory is set. Otherwise it produces a flush request.
- R7: A guest-virtual fence (op code 2) raises a virtual-instruction fault in virtualized S mode, flushes in M mode or non-virtualized S mode, and raises illegal instruction in U mode, virtualized or not.
- R8: A guest-physical fence (op code 3) raises illegal instruction in non-virtualized S mode with trap-virtual-memory set. Otherwise it follows R7.
- R9: The privilege input encodes U as 0, S as 1 and M as 3. The reserved code 2 is treated as M.
- R10: For each cycle with the valid strobe high, exactly one of trap, halt or flush is high in the following cycle, for one cycle. A cycle without the strobe leaves all three low in the following cycle.
- R11: The trap cause output carries 2 for illegal instruction and 22 for virtual instruction. It is zero whenever trap is low.
- R12: While reset is asserted, and after it, until the first request, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 2 | Instruction: 0 wait, 1 supervisor fence, 2 guest-virtual fence, 3 guest-physical fence |
| priv_i | input | 2 | Current privilege: 0 U, 1 S, 3 M (2 treated as M) |
| virt_i | input | 1 | Hart runs virtualized |
| s_ext_i | input | 1 | Supervisor extension enabled |
| h_ext_i | input | 1 | Hypervisor extension enabled |
| m_tw_i | input | 1 | Machine timeout-wait control |
| m_tvm_i | input | 1 | Machine trap-virtual-memory control |
| h_vtw_i | input | 1 | Hypervisor virtual timeout-wait control |
| h_vtvm_i | input | 1 | Hypervisor virtual trap-virtual-memory control |
| halt_req_o | output | 1 | One-cycle halt request |
| flush_req_o | output | 1 | One-cycle translation flush request |
| trap_o | output | 1 | One-cycle exception |
| trap_cause_o | output | CAUSE_W | Exception cause code |

## Verification
Several trap conditions can hold in the same request, and the block must resolve them with the right priority. In virtualized S mode with both timeout-wait and virtual-timeout-wait set, a wait instruction qualifies for both an illegal and a virtual trap. A guest-physical fence in S mode with trap-virtual-memory set toggles between illegal and virtual-fault depending only on the virtualization bit. The bench drives these overlaps directly and also produces them through random control-bit combinations. It judges each answer by the single pulse and the cause code, both computed by a bench-side priority model.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  typedef enum logic [1:0] {
    OP_WFI      = 2'd0,
    OP_SFENCE   = 2'd1,
    OP_HFENCE_V = 2'd2,
    OP_HFENCE_G = 2'd3
  } op_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;

  // Decoded execution context.
  typedef struct packed {
    logic is_u;
    logic is_s;
    logic is_m;
    logic virt;
  } ctx_t;

  // Exactly one field is high for any rule outcome.
  typedef struct packed {
    logic illegal;
    logic virt_fault;
    logic proceed;
  } verdict_t;

endpackage

// File: rtl/ptc_rst_sync.sv
module ptc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[LAST-1:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[LAST];
endmodule

// File: rtl/ptc_ctx_decode.sv
module ptc_ctx_decode
  import ptc_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  output ctx_t       ctx_o
);
  always_comb begin
    ctx_o.is_u = (priv_i == PRIV_U);
    ctx_o.is_s = (priv_i == PRIV_S);
    // Reserved code 2 folds into machine mode.
    ctx_o.is_m = priv_i[1];
    ctx_o.virt = virt_i;
  end
endmodule

// File: rtl/ptc_wfi_rule.sv
module ptc_wfi_rule
  import ptc_pkg::*;
(
  input  ctx_t     ctx_i,
  input  logic     s_ext_i,
  input  logic     tw_i,
  input  logic     vtw_i,
  output verdict_t verdict_o
);
  logic timeout_hit;
  logic user_blocked;
  logic guest_hit;

  always_comb begin
    timeout_hit  = tw_i && (ctx_i.is_s || (ctx_i.is_u && !s_ext_i));
    user_blocked = s_ext_i && ctx_i.is_u && !ctx_i.virt;
    guest_hit    = ctx_i.virt && (ctx_i.is_u || (ctx_i.is_s && vtw_i));

    verdict_o.illegal    = timeout_hit || user_blocked;
    verdict_o.virt_fault = !verdict_o.illegal && guest_hit;
    verdict_o.proceed    = !verdict_o.illegal && !guest_hit;
  end
endmodule

// File: rtl/ptc_sfence_rule.sv
module ptc_sfence_rule
  import ptc_pkg::*;
(
  input  ctx_t     ctx_i,
  input  logic     h_ext_i,
  input  logic     tvm_i,
  input  logic     vtvm_i,
  output verdict_t verdict_o
);
  logic guest_hit;

  always_comb begin
    guest_hit            = h_ext_i && ctx_i.virt && vtvm_i;
    verdict_o.illegal    = ctx_i.is_u || (ctx_i.is_s && tvm_i);
    verdict_o.virt_fault = !verdict_o.illegal && guest_hit;
    verdict_o.proceed    = !verdict_o.illegal && !guest_hit;
  end
endmodule

// File: rtl/ptc_hfence_rule.sv
module ptc_hfence_rule
  import ptc_pkg::*;
#(
  parameter bit GUEST_PHYS = 1'b0
) (
  input  ctx_t     ctx_i,
  input  logic     tvm_i,
  output verdict_t verdict_o
);
  logic tvm_block;
  logic host_ok;
  logic guest_s;

  generate
    if (GUEST_PHYS) begin : g_phys
      assign tvm_block = tvm_i && ctx_i.is_s && !ctx_i.virt;
    end else begin : g_virt
      assign tvm_block = 1'b0;
    end
  endgenerate

  always_comb begin
    guest_s              = ctx_i.is_s && ctx_i.virt;
    host_ok              = ctx_i.is_m || (ctx_i.is_s && !ctx_i.virt);
    verdict_o.virt_fault = !tvm_block && guest_s;
    verdict_o.proceed    = !tvm_block && host_ok;
    verdict_o.illegal    = tvm_block || (!guest_s && !host_ok);
  end
endmodule

// File: rtl/priv_trap_gate.sv
module priv_trap_gate
  import ptc_pkg::*;
#(
  parameter int CAUSE_W      = 5,
  parameter int ILLEGAL_CODE = 2,
  parameter int VIRTUAL_CODE = 22,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  input  logic [1:0]         req_op_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic               s_ext_i,
  input  logic               h_ext_i,
  input  logic               m_tw_i,
  input  logic               m_tvm_i,
  input  logic               h_vtw_i,
  input  logic               h_vtvm_i,
  output logic               halt_req_o,
  output logic               flush_req_o,
  output logic               trap_o,
  output logic [CAUSE_W-1:0] trap_cause_o
);
  localparam logic [CAUSE_W-1:0] ILL_C  = CAUSE_W'(ILLEGAL_CODE);
  localparam logic [CAUSE_W-1:0] VIRT_C = CAUSE_W'(VIRTUAL_CODE);
  localparam int NUM_HF = 2;

  logic rst_sync_n;
  ctx_t ctx;
  verdict_t v_wfi, v_sf, v_sel;
  verdict_t v_hf [NUM_HF];
  op_e op;

  logic               halt_d, flush_d, trap_d;
  logic [CAUSE_W-1:0] cause_d;
  logic               halt_q, flush_q, trap_q;
  logic [CAUSE_W-1:0] cause_q;

  ptc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ptc_ctx_decode u_ctx (.priv_i(priv_i), .virt_i(virt_i), .ctx_o(ctx));

  ptc_wfi_rule u_wfi (
    .ctx_i(ctx), .s_ext_i(s_ext_i), .tw_i(m_tw_i), .vtw_i(h_vtw_i),
    .verdict_o(v_wfi)
  );

  ptc_sfence_rule u_sf (
    .ctx_i(ctx), .h_ext_i(h_ext_i), .tvm_i(m_tvm_i), .vtvm_i(h_vtvm_i),
    .verdict_o(v_sf)
  );

  // Index 0: guest-virtual fence, index 1: guest-physical fence.
  generate
    for (genvar g = 0; g < NUM_HF; g++) begin : g_hf
      ptc_hfence_rule #(.GUEST_PHYS(g == 1)) u_hf (
        .ctx_i(ctx), .tvm_i(m_tvm_i), .verdict_o(v_hf[g])
      );
    end
  endgenerate

  // Next-state logic.
  always_comb begin
    op = op_e'(req_op_i);
    unique case (op)
      OP_WFI:      v_sel = v_wfi;
      OP_SFENCE:   v_sel = v_sf;
      OP_HFENCE_V: v_sel = v_hf[0];
      default:     v_sel = v_hf[1];
    endcase

    halt_d  = 1'b0;
    flush_d = 1'b0;
    trap_d  = 1'b0;
    cause_d = '0;
    if (req_valid_i) begin
      trap_d  = v_sel.illegal || v_sel.virt_fault;
      halt_d  = v_sel.proceed && (op == OP_WFI);
      flush_d = v_sel.proceed && (op != OP_WFI);
      if (v_sel.illegal) begin
        cause_d = ILL_C;
      end else if (v_sel.virt_fault) begin
        cause_d = VIRT_C;
      end
    end
  end

  // Output registers.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      halt_q  <= 1'b0;
      flush_q <= 1'b0;
      trap_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      halt_q  <= halt_d;
      flush_q <= flush_d;
      trap_q  <= trap_d;
      cause_q <= cause_d;
    end
  end

  assign halt_req_o   = halt_q;
  assign flush_req_o  = flush_q;
  assign trap_o       = trap_q;
  assign trap_cause_o = cause_q;

  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid_i |=> $countones({halt_req_o, flush_req_o, trap_o}) == 1);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid_i |=> !halt_req_o && !flush_req_o && !trap_o);

  a_r11_cause_legal: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_o |-> (trap_cause_o == ILL_C || trap_cause_o == VIRT_C));

  a_r11_cause_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !trap_o |-> trap_cause_o == '0);

  a_r4_halt_only_wfi: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid_i && req_op_i != 2'd0) |=> !halt_req_o);

  a_r6_no_flush_on_wfi: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid_i && req_op_i == 2'd0) |=> !flush_req_o);

  a_r7_machine_fence: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid_i && req_op_i[1] && priv_i == 2'd3) |=> flush_req_o);

  a_r5_user_sfence: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid_i && req_op_i == 2'd1 && priv_i == 2'd0) |=>
      trap_o && trap_cause_o == ILL_C);

endmodule

// File: tb/priv_trap_gate_tb_top.sv
module priv_trap_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid_i = 1'b0;
  logic [1:0] req_op_i = '0;
  logic [1:0] priv_i = '0;
  logic virt_i = 1'b0, s_ext_i = 1'b0, h_ext_i = 1'b0;
  logic m_tw_i = 1'b0, m_tvm_i = 1'b0, h_vtw_i = 1'b0, h_vtvm_i = 1'b0;
  logic halt_req_o, flush_req_o, trap_o;
  logic [CW-1:0] trap_cause_o;

  int n_checks = 0;
  int n_fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  priv_trap_gate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
    .priv_i(priv_i), .virt_i(virt_i), .s_ext_i(s_ext_i), .h_ext_i(h_ext_i),
    .m_tw_i(m_tw_i), .m_tvm_i(m_tvm_i), .h_vtw_i(h_vtw_i), .h_vtvm_i(h_vtvm_i),
    .halt_req_o(halt_req_o), .flush_req_o(flush_req_o), .trap_o(trap_o),
    .trap_cause_o(trap_cause_o)
  );

  // Expected {trap, halt, flush, cause} from the requirements.
  // Result kind: 0 illegal, 1 virtual fault, 2 proceed.
  function automatic int kind_of(input logic [1:0] op, input logic [1:0] pv,
                                 input logic v, input logic s, input logic h,
                                 input logic tw, input logic tvm,
                                 input logic vtw, input logic vtvm);
    bit u_m = (pv == 2'd0);
    bit s_m = (pv == 2'd1);
    bit m_m = (pv >= 2'd2);   // R9
    case (op)
      2'd0: begin
        if (tw && s_m) return 0;                 // R1
        if (tw && u_m && !s) return 0;           // R1
        if (u_m && s && !v) return 0;            // R2
        if (v && u_m) return 1;                  // R3
        if (v && s_m && vtw) return 1;           // R3
        return 2;                                // R4
      end
      2'd1: begin
        if (u_m) return 0;                       // R5
        if (s_m && tvm) return 0;                // R5
        if (h && v && vtvm) return 1;            // R6
        return 2;
      end
      default: begin
        if (op == 2'd3 && s_m && !v && tvm) return 0;  // R8
        if (s_m && v) return 1;                  // R7
        if (m_m) return 2;
        if (s_m) return 2;
        return 0;
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] op, input int k);
    case (op)
      2'd0: return (k == 0) ? "R1" : (k == 1) ? "R3" : "R4";
      2'd1: return (k == 2) ? "R6" : (k == 1) ? "R6" : "R5";
      2'd2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check_outs(input string tag, input logic e_trap, input logic e_halt,
                            input logic e_flush, input logic [CW-1:0] e_cause);
    n_checks++;
    if ({trap_o, halt_req_o, flush_req_o, trap_cause_o} !==
        {e_trap, e_halt, e_flush, e_cause}) begin
      n_fails++;
      $display("FAIL %s: got trap=%0b halt=%0b flush=%0b cause=%0d, exp trap=%0b halt=%0b flush=%0b cause=%0d",
               tag, trap_o, halt_req_o, flush_req_o, trap_cause_o,
               e_trap, e_halt, e_flush, e_cause);
    end
  endtask

  // Drive one request at a falling edge, check the answer at the next one.
  task automatic issue(input logic [1:0] op, input logic [1:0] pv, input logic v,
                       input logic s, input logic h, input logic tw, input logic tvm,
                       input logic vtw, input logic vtvm, input string force_tag);
    int k;
    string tg;
    req_valid_i = 1'b1; req_op_i = op; priv_i = pv; virt_i = v;
    s_ext_i = s; h_ext_i = h; m_tw_i = tw; m_tvm_i = tvm;
    h_vtw_i = vtw; h_vtvm_i = vtvm;
    k  = kind_of(op, pv, v, s, h, tw, tvm, vtw, vtvm);
    tg = (force_tag != "") ? force_tag : tag_of(op, k);
    @(negedge clk);
    // R10 single outcome, R11 cause value
    check_outs(tg, k != 2, (k == 2) && (op == 2'd0), (k == 2) && (op != 2'd0),
               (k == 0) ? CW'(2) : (k == 1) ? CW'(22) : CW'(0));
  endtask

  task automatic idle_check(input string tg);
    req_valid_i = 1'b0;
    req_op_i = 2'($urandom); priv_i = 2'($urandom); virt_i = 1'($urandom);
    m_tw_i = 1'($urandom); m_tvm_i = 1'($urandom);
    @(negedge clk);
    check_outs(tg, 1'b0, 1'b0, 1'b0, '0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    #(CLK_PERIOD * 2 + 1);
    // R12: outputs zero under reset
    check_outs("R12", 1'b0, 1'b0, 1'b0, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_outs("R12", 1'b0, 1'b0, 1'b0, '0);

    // Directed corner cases.
    issue(2'd0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R1");   // S, TW
    issue(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1");   // U, no S ext
    issue(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4");   // U, no S ext, TW clear
    issue(2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    issue(2'd0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R1");   // VS: TW beats VTW
    issue(2'd0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R3");
    issue(2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3");   // VU
    issue(2'd0, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R4");   // M ignores TW
    issue(2'd0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9");   // code 2 as M
    issue(2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    issue(2'd1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
    issue(2'd1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
    issue(2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R6");   // no H ext: flush
    issue(2'd1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6");   // M flushes
    issue(2'd2, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    issue(2'd2, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R7");   // TVM ignored
    issue(2'd2, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    issue(2'd3, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    issue(2'd3, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    issue(2'd3, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    idle_check("R10");

    // Constrained random: valid mostly high, privilege mostly legal codes.
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] pv;
      case ($urandom_range(0, 9))
        0, 1, 2: pv = 2'd0;
        3, 4, 5, 6: pv = 2'd1;
        7, 8: pv = 2'd3;
        default: pv = 2'd2;
      endcase
      if ($urandom_range(0, 7) == 0) begin
        idle_check("R10");
      end else begin
        issue(2'($urandom), pv, 1'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "");
      end
    end
    idle_check("R10");

    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule